// File: doc/BRIEF.md
# Double-Buffered Register-Mapped UART

This block is a serial transmitter and receiver that a processor drives through a narrow register port. It has one data address and one control address. Writing the data address queues a byte for sending, and reading it returns the last byte that was received. Reading the control address returns a two-bit status word. Writing the control address sets the baud divisor. The serial lines use positive logic: the line idles high and the start bit is low.

Each direction has a single holding register in front of its shift register. Software can therefore place one byte in the transmit holding register while another byte is being shifted out. In the same way, one received byte waits for software while the next one is being assembled. A single tick generator runs at sixteen times the bit rate and paces both directions. The bit period is 16 × (divisor + 1) system clocks. With a nominal 16.67 MHz clock, a divisor of 8 gives roughly 115200 baud and a divisor of 26 gives roughly 38400 baud.

Software polls the status word. It writes a byte when transmit-full is clear and reads a byte when data-ready is set.

Top module: `dbuf_uart`

## Requirements
- R1: After reset, the divisor is 0, `serTx` is high, and a status read returns 8'h00.
- R2: A write to the data address (default 8'hC0) while transmit-full is clear loads the byte into the transmit holding register and sets transmit-full (status bit 1) from the next cycle.
- R3: A write to the data address while transmit-full is set is ignored. The held byte and the transmitted stream are unchanged.
- R4: Transmit-full clears on the baud tick at which the held byte moves into an idle shifter. On that same clock edge `serTx` drops to the start bit.
- R5: Every transmitted frame has, in this order, one low start bit, 8 data bits least significant bit first, and one high stop bit. Each bit lasts 16 ticks.
- R6: A write to the control address (default 8'hC1) loads the 8-bit divisor and restarts the tick counter. After that, one bit lasts 16 × (divisor + 1) clocks.
- R7: A read of the control address returns data-ready in bit 0, transmit-full in bit 1, and zero in bits 7:2.
- R8: When a received frame has a high stop bit, data-ready (status bit 0) is set and the byte can be read at the data address.
- R9: A read of the data address clears data-ready, unless a new byte completes in the same cycle.
- R10: If a byte completes while data-ready is still set, it replaces the held byte and data-ready stays set.
- R11: A received frame whose stop bit samples low is discarded. Data-ready and the held byte are unchanged.
- R12: A low pulse on `serRx` that is gone by the start-bit midpoint (tick 8) is rejected. The receiver then accepts the next valid frame.
- R13: A byte written while another byte is shifting waits in the holding register. The two bytes go out back to back, in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (side effect on the data address) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from `busAddr` |
| serRx | input | 1 | Serial receive line, idle high |
| serTx | output | 1 | Serial transmit line, idle high |

## Verification
If the transmit holding state is wrong, it shows up as a byte that is lost, duplicated or reordered in the serial stream. It can also show up as a transmit-full bit that stays set. These appear on `serTx` within one frame time, and on a status read within one tick. If the receive phase counter or the data-ready flag is wrong, the block reports a byte that was never sent, or the wrong value. It may also miss a discard, keep a byte after it was read, or accept a start glitch. Each of these is visible at the next status or data read after the frame would have ended. A divisor or tick fault stretches or shrinks the start bit, and that can be measured in clock cycles on the first frame sent after the divisor write.

// File: rtl/dbuf_uart_pkg.sv
`timescale 1ns/1ps
package dbuf_uart_pkg;

  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 2;

  // control -> datapath strobes
  typedef struct packed {
    logic              divLoad;
    logic [BYTE_W-1:0] divValue;
    logic              txPending;
    logic [BYTE_W-1:0] txByte;
  } ctrl_strobe_t;

  // datapath -> control events
  typedef struct packed {
    logic              txTake;
    logic              rxDone;
    logic [BYTE_W-1:0] rxByte;
  } dp_event_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

endpackage

// File: rtl/dbuf_uart_ctrl.sv
`timescale 1ns/1ps
module dbuf_uart_ctrl
  import dbuf_uart_pkg::*;
#(
  parameter logic [7:0] DATA_ADDR = 8'hC0,
  parameter logic [7:0] CTRL_ADDR = 8'hC1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  dp_event_t         evt,
  output ctrl_strobe_t      strobe,
  output logic [1:0]        statusBits
);

  logic              txFull, dataReady;
  logic [BYTE_W-1:0] txHold, rxHold;
  logic              wrData, wrCtrl, rdData;

  assign wrData = busWrEn && (busAddr == DATA_ADDR);
  assign wrCtrl = busWrEn && (busAddr == CTRL_ADDR);
  assign rdData = busRdEn && (busAddr == DATA_ADDR);

  // transmit holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFull <= 1'b0;
      txHold <= '0;
    end else if (evt.txTake) begin
      txFull <= 1'b0;
    end else if (wrData && !txFull) begin
      txHold <= busWrData;
      txFull <= 1'b1;
    end
  end

  // receive holding register: a finished byte wins over a read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      rxHold    <= '0;
    end else if (evt.rxDone) begin
      rxHold    <= evt.rxByte;
      dataReady <= 1'b1;
    end else if (rdData) begin
      dataReady <= 1'b0;
    end
  end

  assign statusBits = {txFull, dataReady};

  always_comb begin
    strobe.divLoad   = wrCtrl;
    strobe.divValue  = busWrData;
    strobe.txPending = txFull;
    strobe.txByte    = txHold;
  end

  always_comb begin
    if (busAddr == DATA_ADDR)      busRdData = rxHold;
    else if (busAddr == CTRL_ADDR) busRdData = {{(BYTE_W-2){1'b0}}, statusBits};
    else                           busRdData = '0;
  end

endmodule

// File: rtl/dbuf_uart_dp.sv
`timescale 1ns/1ps
module dbuf_uart_dp
  import dbuf_uart_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output dp_event_t    evt,
  input  logic         serRx,
  output logic         serTx
);

  localparam int PH_W  = $clog2(OVERSAMPLE);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVERSAMPLE - 1);
  localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(BYTE_W - 1);

  // ---------------- baud tick generator ----------------
  logic [BYTE_W-1:0] divReg, tickCnt;
  logic              baudTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg  <= '0;
      tickCnt <= '0;
    end else if (strobe.divLoad) begin
      divReg  <= strobe.divValue;
      tickCnt <= '0;
    end else if (tickCnt == divReg) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + BYTE_W'(1);
    end
  end

  assign baudTick = (tickCnt == divReg) && !strobe.divLoad;

  // ---------------- transmit shifter ----------------
  logic               txBusy, txTake;
  logic [FRAME_W-1:0] txShift;
  logic [PH_W-1:0]    txPhase;
  logic [CNT_W-1:0]   txBitCnt;

  assign txTake = baudTick && !txBusy && strobe.txPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      txShift  <= '1;
      txPhase  <= '0;
      txBitCnt <= '0;
    end else if (txTake) begin
      txShift  <= {1'b1, strobe.txByte, 1'b0};
      txBusy   <= 1'b1;
      txPhase  <= '0;
      txBitCnt <= '0;
    end else if (txBusy && baudTick) begin
      if (txPhase == PH_LAST) begin
        txPhase <= '0;
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
        if (txBitCnt == TX_LAST) txBusy   <= 1'b0;
        else                     txBitCnt <= txBitCnt + CNT_W'(1);
      end else begin
        txPhase <= txPhase + PH_W'(1);
      end
    end
  end

  assign serTx = txShift[0];

  // ---------------- receive synchronizer ----------------
  logic [SYNC_STAGES-1:0] rxSync;
  logic                   rxBit;

  always_ff @(posedge clk) begin
    if (!rstN) rxSync <= '1;
    else       rxSync <= {rxSync[SYNC_STAGES-2:0], serRx};
  end
  assign rxBit = rxSync[SYNC_STAGES-1];

  // ---------------- receive shifter ----------------
  rx_state_e         rxState;
  logic [PH_W-1:0]   rxPhase;
  logic [CNT_W-1:0]  rxBitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic              rxDoneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxPhase  <= '0;
      rxBitCnt <= '0;
      rxShift  <= '0;
      rxDoneQ  <= 1'b0;
    end else begin
      rxDoneQ <= 1'b0;
      if (baudTick) begin
        case (rxState)
          RX_IDLE: begin
            if (!rxBit) begin
              rxState <= RX_START;
              rxPhase <= '0;
            end
          end
          RX_START: begin
            if (rxPhase == PH_MID) begin
              rxPhase  <= '0;
              rxBitCnt <= '0;
              rxState  <= rxBit ? RX_IDLE : RX_DATA;
            end else begin
              rxPhase <= rxPhase + PH_W'(1);
            end
          end
          RX_DATA: begin
            if (rxPhase == PH_LAST) begin
              rxPhase <= '0;
              rxShift <= {rxBit, rxShift[BYTE_W-1:1]};
              if (rxBitCnt == RX_LAST) rxState  <= RX_STOP;
              else                     rxBitCnt <= rxBitCnt + CNT_W'(1);
            end else begin
              rxPhase <= rxPhase + PH_W'(1);
            end
          end
          default: begin
            if (rxPhase == PH_LAST) begin
              rxDoneQ <= rxBit;
              rxState <= RX_IDLE;
              rxPhase <= '0;
            end else begin
              rxPhase <= rxPhase + PH_W'(1);
            end
          end
        endcase
      end
    end
  end

  assign evt.txTake = txTake;
  assign evt.rxDone = rxDoneQ;
  assign evt.rxByte = rxShift;

endmodule

// File: rtl/dbuf_uart.sv
`timescale 1ns/1ps
module dbuf_uart
  import dbuf_uart_pkg::*;
#(
  parameter logic [7:0] DATA_ADDR   = 8'hC0,
  parameter logic [7:0] CTRL_ADDR   = 8'hC1,
  parameter int         OVERSAMPLE  = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       serRx,
  output logic       serTx
);

  ctrl_strobe_t ctrlStrobe;
  dp_event_t    dpEvt;
  logic [1:0]   statusBits;

  dbuf_uart_ctrl #(.DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .evt(dpEvt), .strobe(ctrlStrobe), .statusBits(statusBits)
  );

  dbuf_uart_dp #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .evt(dpEvt),
    .serRx(serRx), .serTx(serTx)
  );

endmodule

// File: rtl/dbuf_uart_chk.sv
`timescale 1ns/1ps
module dbuf_uart_chk #(
  parameter logic [7:0] DATA_ADDR = 8'hC0,
  parameter logic [7:0] CTRL_ADDR = 8'hC1
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busAddr,
  input logic       busWrEn,
  input logic       busRdEn,
  input logic [7:0] busRdData,
  input logic [1:0] statusBits,
  input logic       rxDone,
  input logic       serTx
);

  assert_write_sets_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == DATA_ADDR && !statusBits[1]) |=> statusBits[1]);

  assert_take_starts_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusBits[1]) |-> !serTx);

  assert_status_layout_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == CTRL_ADDR) |-> (busRdData[7:2] == 6'd0 && busRdData[1:0] == statusBits));

  assert_done_sets_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> statusBits[0]);

  assert_read_clears_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == DATA_ADDR && !rxDone) |=> !statusBits[0]);

endmodule

bind dbuf_uart dbuf_uart_chk #(.DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)) i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busRdData(busRdData), .statusBits(statusBits),
  .rxDone(dpEvt.rxDone), .serTx(serTx)
);

// File: tb/test_dbuf_uart.sv
`timescale 1ns/1ps
module test_dbuf_uart;

  localparam logic [7:0] DATA_A = 8'hC0;
  localparam logic [7:0] CTRL_A = 8'hC1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       serRx = 1'b1;
  logic       serTx;

  int checks = 0;
  int errors = 0;
  int bitCycles = 16;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  dbuf_uart i_dbuf_uart (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .serRx(serRx), .serTx(serTx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    expQ.push_back(d);
    writeReg(DATA_A, d);
  endtask

  task automatic driveFrame(input logic [7:0] d, input logic stopVal);
    @(negedge clk);
    serRx = 1'b0;
    repeat (bitCycles) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serRx = d[i];
      repeat (bitCycles) @(negedge clk);
    end
    serRx = stopVal;
    repeat (bitCycles) @(negedge clk);
    serRx = 1'b1;
    repeat (bitCycles) @(negedge clk);
  endtask

  task automatic drainTx();
    while (expQ.size() != 0) @(negedge clk);
    repeat (12 * bitCycles) @(negedge clk);
  endtask

  // monitor: decodes serTx frames and compares them with the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && serTx == 1'b0) begin
        int bc;
        logic [7:0] got;
        logic [7:0] exp;
        bc = bitCycles;
        repeat (bc / 2) @(negedge clk);
        check(serTx == 1'b0, "R5 start bit low", serTx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bc) @(negedge clk);
          got[i] = serTx;
        end
        repeat (bc) @(negedge clk);
        check(serTx == 1'b1, "R5 stop bit high", serTx, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected frame", got, 0);
        end else begin
          exp = expQ.pop_front();
          check(got == exp, "R5/R13 frame data LSB first", got, exp);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    int width;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(CTRL_A, rd);
    check(rd == 8'h00, "R1 status after reset", rd, 0);
    check(serTx == 1'b1, "R1 tx idle high", serTx, 1);

    // R2 / R4 with the reset divisor 0 (tick every clock)
    sendByte(8'hA5);
    busAddr = CTRL_A;
    #1 check(busRdData == 8'h02, "R2 transmit-full set", busRdData, 2);
    check(serTx == 1'b1, "R4 line high before take", serTx, 1);
    @(negedge clk);
    check(busRdData == 8'h00, "R4 transmit-full cleared on take", busRdData, 0);
    check(serTx == 1'b0, "R4 start bit on take", serTx, 0);

    // R13 second byte waits; R3 third byte ignored
    sendByte(8'h3C);
    writeReg(DATA_A, 8'hE7);
    readReg(CTRL_A, rd);
    check(rd == 8'h02, "R3 still full after ignored write", rd, 2);
    drainTx();

    // R6 divisor 3: start bit lasts 64 clocks
    writeReg(CTRL_A, 8'd3);
    bitCycles = 64;
    sendByte(8'hFF);
    while (serTx != 1'b0) @(negedge clk);
    width = 0;
    while (serTx == 1'b0) begin
      width++;
      @(negedge clk);
    end
    check(width == 64, "R6 bit period with divisor 3", width, 64);
    sendByte(8'h81);
    drainTx();
    writeReg(CTRL_A, 8'd0);
    bitCycles = 16;

    // R8 / R9 receive and clear
    driveFrame(8'h5A, 1'b1);
    readReg(CTRL_A, rd);
    check(rd == 8'h01, "R8 data-ready set", rd, 1);
    readReg(DATA_A, rd);
    check(rd == 8'h5A, "R8 received byte", rd, 8'h5A);
    readReg(CTRL_A, rd);
    check(rd == 8'h00, "R9 data-ready cleared by read", rd, 0);

    // R10 overwrite while ready
    driveFrame(8'h11, 1'b1);
    driveFrame(8'h22, 1'b1);
    readReg(CTRL_A, rd);
    check(rd == 8'h01, "R10 ready stays set", rd, 1);

    // R7 both status bits together
    sendByte(8'h69);
    sendByte(8'h96);
    readReg(CTRL_A, rd);
    check(rd == 8'h03, "R7 status layout both set", rd, 3);
    drainTx();

    readReg(DATA_A, rd);
    check(rd == 8'h22, "R10 newer byte replaces held", rd, 8'h22);

    // R11 bad stop bit discarded
    driveFrame(8'h77, 1'b0);
    repeat (40) @(negedge clk);
    readReg(CTRL_A, rd);
    check(rd == 8'h00, "R11 no ready after bad stop", rd, 0);
    busAddr = DATA_A;
    #1 check(busRdData == 8'h22, "R11 held byte unchanged", busRdData, 8'h22);

    // R12 short glitch rejected, next frame accepted
    @(negedge clk);
    serRx = 1'b0;
    repeat (4) @(negedge clk);
    serRx = 1'b1;
    repeat (300) @(negedge clk);
    readReg(CTRL_A, rd);
    check(rd == 8'h00, "R12 glitch rejected", rd, 0);
    driveFrame(8'hC3, 1'b1);
    readReg(DATA_A, rd);
    check(rd == 8'hC3, "R12 frame after glitch", rd, 8'hC3);

    check(expQ.size() == 0, "R13 all queued frames sent", expQ.size(), 0);
    finishRun();
  end

endmodule